// File: doc/BRIEF.md
# Relocating Display Program Counter

This block holds the fetch address of a display-list processor and turns it into a physical memory address. A 12-bit relocation value is shifted up by six bit positions and added to the 16-bit byte counter. The result is an 18-bit physical byte address. The fetch side sees the 17-bit word part of that address, and each advance strobe steps the counter by one word.

A host reaches the block through a small select/write/read port. Writing the counter with an even value loads it and sends a one-cycle start pulse to the sequencer. Writing it with bit 0 set sends a resume pulse instead and leaves the counter as it is. A read of the counter returns a partly relocated value rather than the value that was written. A separate status select returns the two top physical address bits. The relocation register can be written and read back.

Top module: `reloc_dpc`

## Requirements
- R1: While reset is high and in the first cycle after it, the counter, the relocation value, fetch_addr, start_pulse and resume_pulse are all zero.
- R2: fetch_addr equals bits 17:1 of (counter + relocation*64) mod 2^18.
- R3: A host read with select 0 returns (counter + (relocation bits 8:0)*64) mod 2^16, and its bit 0 is always zero.
- R4: A host write with select 0 and data bit 0 clear loads the counter with the data and bit 0 forced to zero. start_pulse is high for exactly the one cycle after that write edge.
- R5: A host write with select 0 and data bit 0 set leaves the counter unchanged. resume_pulse is high for exactly the one cycle after that write edge, and start_pulse stays low.
- R6: When fetch_adv is high on a clock edge, the counter grows by 2 modulo 2^16. A host counter write on the same edge takes priority, and that advance is dropped.
- R7: A host write with select 1 stores data bits 11:0 as the relocation value. A read with select 1 returns that value with bits 15:12 zero.
- R8: A read with select 2 returns physical address bits 17:16 in bits 1:0, with all other bits zero. A read with select 3 returns zero. Writes with select 2 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Host register select (0 counter, 1 relocation, 2 status, 3 unused) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the current select |
| fetch_adv | input | 1 | Advance the counter by one word |
| fetch_addr | output | 17 | Relocated physical word address |
| start_pulse | output | 1 | One-cycle start request to the sequencer |
| resume_pulse | output | 1 | One-cycle resume request to the sequencer |

## Verification
Some properties are checked on every cycle. These are the one-word step after an advance, the counter holding still across a resume, the start pulse following only an even counter write, the relocation register taking its write data, and the pulses being quiet after reset.

Other behaviour depends on the exact arithmetic, so only the bench scenarios can show it. This covers the two different adder widths, where relocation bit 9 reaches the fetch address but not the counter read, and the carry into physical bits 17:16 and out of bit 17. It also covers the wrap of the counter, the collision of a write with an advance, and writes to the status and unused selects having no effect.

// File: rtl/reloc_dpc_pkg.sv
package reloc_dpc_pkg;

    localparam int CNT_W     = 16;
    localparam int REL_W     = 12;
    localparam int REL_SHIFT = 6;
    localparam int RD_REL_W  = 9;
    localparam int PHYS_W    = CNT_W + 2;
    localparam int FETCH_W   = PHYS_W - 1;

    typedef enum logic [1:0] {
        SEL_CNT    = 2'd0,
        SEL_REL    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic start;
        logic resume;
    } seq_req_t;

    function automatic logic [CNT_W-1:0] word_align(input logic [CNT_W-1:0] v);
        return {v[CNT_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/dpc_counter.sv
module dpc_counter
    import reloc_dpc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_cnt,
    input  logic [W-1:0] wdata,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output seq_req_t     req
);
    localparam logic [W-1:0] STEP = W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            req <= '0;
        end else begin
            req <= '0;
            if (wr_cnt) begin
                if (wdata[0]) begin
                    req.resume <= 1'b1;
                end else begin
                    cnt       <= word_align(wdata);
                    req.start <= 1'b1;
                end
            end else if (adv) begin
                cnt <= cnt + STEP;
            end
        end
    end

    // R6
    adv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_cnt) |=> (cnt == $past(cnt) + STEP));

    // R5
    resume_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && wdata[0]) |=> (cnt == $past(cnt)));

    // R4
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        req.start |-> ($past(wr_cnt) && !$past(wdata[0])));

endmodule

// File: rtl/dpc_reloc_reg.sv
module dpc_reloc_reg
    import reloc_dpc_pkg::*;
#(
    parameter int W = REL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_rel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rel
);
    always_ff @(posedge clk) begin
        if (rst)         rel <= '0;
        else if (wr_rel) rel <= wdata;
    end

    // R7
    rel_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_rel |=> (rel == $past(wdata)));

endmodule

// File: rtl/dpc_addr_form.sv
module dpc_addr_form
    import reloc_dpc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = REL_W,
    parameter int SH = REL_SHIFT,
    parameter int RDW = RD_REL_W,
    parameter int PW = CW + 2
) (
    input  logic [CW-1:0] cnt,
    input  logic [RW-1:0] rel,
    output logic [PW-1:0] phys,
    output logic [CW-1:0] cnt_view
);
    localparam int REL_SPAN = RW + SH;
    localparam int RD_SPAN  = RDW + SH;

    logic [REL_SPAN-1:0] rel_full;
    logic [RD_SPAN-1:0]  rel_part;

    generate
        if (REL_SPAN > PW) begin : g_rel_trim
            assign phys = PW'({(REL_SPAN - CW)'(0), cnt} + {rel, SH'(0)});
        end else begin : g_rel_fit
            assign phys = {(PW - CW)'(0), cnt} + PW'({rel, SH'(0)});
        end
    endgenerate

    assign rel_full = {rel, SH'(0)};
    assign rel_part = {rel[RDW-1:0], SH'(0)};
    assign cnt_view = cnt + CW'(rel_part);

    // R2
    always_comb begin
        if (rel_full == '0)
            phys_passthru_chk: assert (phys[CW-1:0] == cnt);
    end

endmodule

// File: rtl/reloc_dpc.sv
module reloc_dpc
    import reloc_dpc_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int RW = REL_W,
    parameter int SH = REL_SHIFT,
    parameter int RDW = RD_REL_W,
    parameter int PW = CW + 2,
    parameter int FW = PW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [CW-1:0] host_wdata,
    output logic [CW-1:0] host_rdata,
    input  logic          fetch_adv,
    output logic [FW-1:0] fetch_addr,
    output logic          start_pulse,
    output logic          resume_pulse
);
    host_sel_e     sel;
    logic          wr_cnt;
    logic          wr_rel;
    logic [CW-1:0] cnt;
    logic [RW-1:0] rel;
    logic [PW-1:0] phys;
    logic [CW-1:0] cnt_view;
    seq_req_t      req;

    assign sel    = host_sel_e'(host_sel);
    assign wr_cnt = host_wr && (sel == SEL_CNT);
    assign wr_rel = host_wr && (sel == SEL_REL);

    dpc_counter #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .wr_cnt (wr_cnt),
        .wdata  (host_wdata),
        .adv    (fetch_adv),
        .cnt    (cnt),
        .req    (req)
    );

    dpc_reloc_reg #(.W(RW)) u_rel (
        .clk    (clk),
        .rst    (rst),
        .wr_rel (wr_rel),
        .wdata  (host_wdata[RW-1:0]),
        .rel    (rel)
    );

    dpc_addr_form #(.CW(CW), .RW(RW), .SH(SH), .RDW(RDW), .PW(PW)) u_form (
        .cnt      (cnt),
        .rel      (rel),
        .phys     (phys),
        .cnt_view (cnt_view)
    );

    assign fetch_addr   = phys[PW-1:1];
    assign start_pulse  = req.start;
    assign resume_pulse = req.resume;

    always_comb begin
        unique case (sel)
            SEL_CNT:    host_rdata = cnt_view;
            SEL_REL:    host_rdata = CW'(rel);
            SEL_STATUS: host_rdata = CW'(phys[PW-1:CW]);
            default:    host_rdata = '0;
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!start_pulse && !resume_pulse && fetch_addr == '0));

    // R4
    start_once_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> (!start_pulse || $past(wr_cnt)));

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_pulse, resume_pulse}));

endmodule

// File: tb/reloc_dpc_tb.sv
`timescale 1ns/1ps
module reloc_dpc_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr;
    logic [1:0]  host_sel;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        fetch_adv;
    logic [16:0] fetch_addr;
    logic        start_pulse;
    logic        resume_pulse;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    reloc_dpc dut_i (
        .clk          (clk),
        .rst          (rst),
        .host_wr      (host_wr),
        .host_sel     (host_sel),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .fetch_adv    (fetch_adv),
        .fetch_addr   (fetch_addr),
        .start_pulse  (start_pulse),
        .resume_pulse (resume_pulse)
    );

    typedef struct packed {
        logic [15:0] rel;
        logic [15:0] cnt;
        logic [16:0] fa;
        logic [15:0] rd;
        logic [1:0]  st;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0000, 16'h1234, 17'h0091A, 16'h1234, 2'b00},
        '{16'h0001, 16'h0100, 17'h000A0, 16'h0140, 2'b00},
        '{16'h0800, 16'h0002, 17'h10001, 16'h0002, 2'b10},
        '{16'h0200, 16'h4000, 17'h06000, 16'h4000, 2'b00},
        '{16'h03FF, 16'h8000, 17'h0BFE0, 16'hFFC0, 2'b01},
        '{16'h0FFF, 16'hFFFE, 17'h07FDF, 16'h7FBE, 2'b00}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1;
        host_sel = s;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] s, output logic [15:0] d);
        host_sel = s;
        #1;
        d = host_rdata;
    endtask

    task automatic advance();
        @(negedge clk);
        fetch_adv = 1'b1;
        @(negedge clk);
        fetch_adv = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        rst = 1'b1;
        host_wr = 1'b0;
        host_sel = 2'd0;
        host_wdata = '0;
        fetch_adv = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state, checked during reset and just after it
        host_read(2'd0, r); check("R1 cnt read in reset", r, 0);
        check("R1 fetch_addr in reset", fetch_addr, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        host_read(2'd1, r); check("R1 reloc after reset", r, 0);
        check("R1 pulses after reset", {start_pulse, resume_pulse}, 0);
        check("R1 fetch_addr after reset", fetch_addr, 0);

        // R2 R3 R8 vector table
        for (int i = 0; i < 6; i++) begin
            host_write(2'd1, VECS[i].rel);
            host_write(2'd0, VECS[i].cnt);
            @(negedge clk);
            check($sformatf("R2 fetch_addr vec %0d", i), fetch_addr, VECS[i].fa);
            host_read(2'd0, r); check($sformatf("R3 cnt read vec %0d", i), r, VECS[i].rd);
            host_read(2'd2, r); check($sformatf("R8 status vec %0d", i), r, {14'd0, VECS[i].st});
        end

        // R7 upper relocation bits read as zero
        host_write(2'd1, 16'hFFFF);
        host_read(2'd1, r); check("R7 reloc readback", r, 16'h0FFF);
        host_write(2'd1, 16'h0000);

        // R4 start pulse, one cycle, bit 0 dropped
        host_write(2'd0, 16'h2468);
        check("R4 start high", start_pulse, 1);
        check("R4 resume low on load", resume_pulse, 0);
        host_read(2'd0, r); check("R4 loaded value", r, 16'h2468);
        @(negedge clk);
        check("R4 start one cycle", start_pulse, 0);

        // R5 resume keeps counter
        host_write(2'd0, 16'h0F01);
        check("R5 resume high", resume_pulse, 1);
        check("R5 no start on resume", start_pulse, 0);
        host_read(2'd0, r); check("R5 counter kept", r, 16'h2468);
        @(negedge clk);
        check("R5 resume one cycle", resume_pulse, 0);

        // R6 advance and wrap
        advance();
        host_read(2'd0, r); check("R6 advance step", r, 16'h246A);
        host_write(2'd0, 16'hFFFE);
        advance();
        host_read(2'd0, r); check("R6 wrap to zero", r, 16'h0000);
        check("R6 wrap fetch_addr", fetch_addr, 0);

        // R6 write wins over advance on the same edge
        @(negedge clk);
        host_wr = 1'b1; host_sel = 2'd0; host_wdata = 16'h0400; fetch_adv = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; fetch_adv = 1'b0;
        host_read(2'd0, r); check("R6 write priority", r, 16'h0400);

        // R8 writes to status and unused selects are ignored
        host_write(2'd1, 16'h0800);
        host_write(2'd0, 16'h0002);
        host_write(2'd2, 16'h0000);
        host_write(2'd3, 16'hFFFF);
        host_read(2'd2, r); check("R8 status after ignored writes", r, 16'h0002);
        host_read(2'd0, r); check("R8 cnt after ignored writes", r, 16'h0002);
        host_read(2'd1, r); check("R8 reloc after ignored writes", r, 16'h0800);
        host_read(2'd3, r); check("R8 unused select reads zero", r, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule